// File: doc/BRIEF.md
# Deblocking edge mask and variance detector

This block decides, for each line of pixels that crosses a block boundary, whether the boundary should be smoothed and which kind of smoothing suits it. Each line holds eight unsigned 8-bit samples, four on each side of the boundary. The block compares local gradients against three shared thresholds. It returns a byte-wide enable mask and a one-bit high-variance flag for each line.

A parameter sets how many lines (lanes) are examined at once. Every lane has its own eight samples. The inner limit, the boundary limit and the variance threshold are shared by all lanes. The block has one register stage. The decision for a line appears one clock after it is accepted, together with a copy of the line's samples, so that a downstream pixel filter can consume both in the same cycle.

Top module: `edge_gate_detect`

## Requirements
- R1: Within a lane, byte k of the 64-bit line (bits 8k+7..8k) carries tap k in the order p3, p2, p1, p0, q0, q1, q2, q3 (k = 0..7). Every difference the block uses is the unsigned absolute difference of two 8-bit taps.
- R2: The inner condition holds when the largest of the six same-side neighbour differences (p3/p2, p2/p1, p1/p0, q0/q1, q1/q2, q2/q3) is less than or equal to `lim_inner`. Equality passes.
- R3: The boundary term is min(255, min(255, 2·|p0−q0|) + floor(|p1−q1|/2)). The boundary condition holds when this term is less than or equal to `lim_edge`.
- R4: A lane's mask byte is 0xFF when both the inner condition and the boundary condition hold, and 0x00 otherwise.
- R5: A lane's high-variance flag is 1 exactly when max(|p1−p0|, |q1−q0|) is strictly greater than `var_thr`.
- R6: Lanes are independent. Lane n uses only bits [64n+63:64n] of `pix_in`, and drives mask bits [8n+7:8n] and flag bit n.
- R7: `valid_out` equals `valid_in` from one clock earlier. The mask and flag for a line accepted at one edge are presented after that edge.
- R8: `pix_out` is the `pix_in` value accepted one clock earlier.
- R9: While `valid_in` is low, `pix_out`, `mask_out` and `hev_out` keep their previous values, whatever `pix_in` and the thresholds do.
- R10: While `rst_n` is low, every output register clears to zero at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | The lines on `pix_in` are accepted this cycle |
| pix_in | input | LANES*64 | Eight taps per lane, p3 in the lowest byte |
| lim_inner | input | 8 | Limit on the same-side neighbour differences |
| lim_edge | input | 8 | Limit on the boundary term |
| var_thr | input | 8 | Threshold for the high-variance flag |
| valid_out | output | 1 | Registered copy of `valid_in` |
| pix_out | output | LANES*64 | Registered copy of the accepted lines |
| mask_out | output | LANES*8 | Per-lane enable byte, 0xFF or 0x00 |
| hev_out | output | LANES | Per-lane high-variance flag |

## Verification
The bench builds the block with four lanes. This is enough to give each lane its own directed pattern in the same cycle, so a crossed lane index or a mis-sliced byte shows up, while the random phase stays short. The directed vectors put each neighbour difference exactly at its limit and one above it. They drive |p0−q0| large enough to make the doubling saturate, and use an odd |p1−q1| to expose the halving. The random phase toggles `valid_in` and thresholds, so that hold behaviour and the pass-through are compared against the reference on every clock.

// File: rtl/edge_gate_pkg.sv
package edge_gate_pkg;
    localparam int PIX_W  = 8;
    localparam int TAPS   = 8;
    localparam int LINE_W = PIX_W * TAPS;

    // tap positions inside one line, outermost p-side tap first
    localparam int TAP_P1 = 2;
    localparam int TAP_P0 = 3;
    localparam int TAP_Q0 = 4;
    localparam int TAP_Q1 = 5;

    // adjacent-difference index k compares tap k with tap k+1
    localparam int ADJ_CROSS = TAP_P0;   // p0 against q0
    localparam int ADJ_PIN   = TAP_P1;   // p1 against p0
    localparam int ADJ_QIN   = TAP_Q0;   // q0 against q1

    typedef logic [PIX_W-1:0] pix_t;
endpackage

// File: rtl/edge_gate_absdiff.sv
module edge_gate_absdiff #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] d_o
);
    logic [W-1:0] a_minus_b;
    logic [W-1:0] b_minus_a;

    // two clamped subtractions; at most one is non-zero
    always_comb begin
        a_minus_b = (a_i > b_i) ? a_i - b_i : '0;
        b_minus_a = (b_i > a_i) ? b_i - a_i : '0;
        d_o       = a_minus_b | b_minus_a;
    end
endmodule

// File: rtl/edge_gate_lane.sv
module edge_gate_lane
    import edge_gate_pkg::*;
(
    input  logic [LINE_W-1:0] line_i,
    input  pix_t              lim_inner_i,
    input  pix_t              lim_edge_i,
    input  pix_t              var_thr_i,
    output pix_t              mask_o,
    output logic              hev_o
);
    pix_t tap [TAPS];
    pix_t adj [TAPS-1];
    pix_t outer_d;

    pix_t         inner_max;
    logic [PIX_W:0] dbl_wide;
    pix_t         dbl_sat;
    pix_t         half_outer;
    logic [PIX_W:0] sum_wide;
    pix_t         bound_term;
    pix_t         inner_act;

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        assign tap[g] = line_i[g*PIX_W +: PIX_W];
    end

    for (genvar g = 0; g < TAPS-1; g++) begin : g_adj
        edge_gate_absdiff #(.W(PIX_W)) u_adj (
            .a_i (tap[g]),
            .b_i (tap[g+1]),
            .d_o (adj[g])
        );
    end

    edge_gate_absdiff #(.W(PIX_W)) u_outer (
        .a_i (tap[TAP_P1]),
        .b_i (tap[TAP_Q1]),
        .d_o (outer_d)
    );

    always_comb begin
        inner_max = '0;
        for (int k = 0; k < TAPS-1; k++) begin
            if (k != ADJ_CROSS && adj[k] > inner_max) begin
                inner_max = adj[k];
            end
        end

        dbl_wide   = {adj[ADJ_CROSS], 1'b0};
        dbl_sat    = dbl_wide[PIX_W] ? '1 : dbl_wide[PIX_W-1:0];
        half_outer = outer_d >> 1;
        sum_wide   = {1'b0, dbl_sat} + {1'b0, half_outer};
        bound_term = sum_wide[PIX_W] ? '1 : sum_wide[PIX_W-1:0];

        mask_o = ((inner_max <= lim_inner_i) && (bound_term <= lim_edge_i)) ? '1 : '0;

        inner_act = (adj[ADJ_PIN] > adj[ADJ_QIN]) ? adj[ADJ_PIN] : adj[ADJ_QIN];
        hev_o     = (inner_act > var_thr_i);
    end
endmodule

// File: rtl/edge_gate_detect.sv
module edge_gate_detect
    import edge_gate_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_in,
    input  logic [LANES*LINE_W-1:0]  pix_in,
    input  logic [PIX_W-1:0]         lim_inner,
    input  logic [PIX_W-1:0]         lim_edge,
    input  logic [PIX_W-1:0]         var_thr,
    output logic                     valid_out,
    output logic [LANES*LINE_W-1:0]  pix_out,
    output logic [LANES*PIX_W-1:0]   mask_out,
    output logic [LANES-1:0]         hev_out
);
    localparam int PIX_BUS_W  = LANES * LINE_W;
    localparam int MASK_BUS_W = LANES * PIX_W;

    typedef struct packed {
        logic                  vld;
        logic [PIX_BUS_W-1:0]  pix;
        logic [MASK_BUS_W-1:0] mask;
        logic [LANES-1:0]      hev;
    } stage_t;

    stage_t st_d;
    stage_t st_q;

    logic [MASK_BUS_W-1:0] lane_mask;
    logic [LANES-1:0]      lane_hev;

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        edge_gate_lane u_lane (
            .line_i      (pix_in[n*LINE_W +: LINE_W]),
            .lim_inner_i (lim_inner),
            .lim_edge_i  (lim_edge),
            .var_thr_i   (var_thr),
            .mask_o      (lane_mask[n*PIX_W +: PIX_W]),
            .hev_o       (lane_hev[n])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_in;
        if (valid_in) begin
            st_d.pix  = pix_in;
            st_d.mask = lane_mask;
            st_d.hev  = lane_hev;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_out = st_q.vld;
    assign pix_out   = st_q.pix;
    assign mask_out  = st_q.mask;
    assign hev_out   = st_q.hev;
endmodule

// File: rtl/edge_gate_detect_chk.sv
module edge_gate_detect_chk
    import edge_gate_pkg::*;
#(
    parameter int LANES = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     valid_in,
    input logic [LANES*LINE_W-1:0]  pix_in,
    input logic [PIX_W-1:0]         lim_inner,
    input logic [PIX_W-1:0]         lim_edge,
    input logic [PIX_W-1:0]         var_thr,
    input logic                     valid_out,
    input logic [LANES*LINE_W-1:0]  pix_out,
    input logic [LANES*PIX_W-1:0]   mask_out,
    input logic [LANES-1:0]         hev_out
);
    a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
    a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);
    a_r8_pix_copy: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (pix_out == $past(pix_in)));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ($stable(pix_out) && $stable(mask_out) && $stable(hev_out)));
    a_r2_open_limits: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && lim_inner == '1 && lim_edge == '1) |=> (mask_out == '1));
    a_r5_top_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && var_thr == '1) |=> (hev_out == '0));
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!valid_out && pix_out == '0 && mask_out == '0 && hev_out == '0));

    for (genvar n = 0; n < LANES; n++) begin : g_mask
        a_r4_mask_byte: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_out[n*PIX_W +: PIX_W] == '0) || (mask_out[n*PIX_W +: PIX_W] == '1));
    end
endmodule

bind edge_gate_detect edge_gate_detect_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .pix_in    (pix_in),
    .lim_inner (lim_inner),
    .lim_edge  (lim_edge),
    .var_thr   (var_thr),
    .valid_out (valid_out),
    .pix_out   (pix_out),
    .mask_out  (mask_out),
    .hev_out   (hev_out)
);

// File: tb/edge_gate_detect_bench.sv
module edge_gate_detect_bench;
    localparam int LANES = 4;
    localparam int LW    = 64;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 valid_in = 1'b0;
    logic [LANES*LW-1:0]  pix_in = '0;
    logic [7:0]           lim_inner = 8'd0;
    logic [7:0]           lim_edge = 8'd0;
    logic [7:0]           var_thr = 8'd0;
    logic                 valid_out;
    logic [LANES*LW-1:0]  pix_out;
    logic [LANES*8-1:0]   mask_out;
    logic [LANES-1:0]     hev_out;

    int checks = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R10";

    logic                exp_vld = 1'b0;
    logic [LANES*LW-1:0] exp_pix = '0;
    logic [LANES*8-1:0]  exp_mask = '0;
    logic [LANES-1:0]    exp_hev = '0;

    always #10 clk = ~clk;

    edge_gate_detect #(.LANES(LANES)) u_edge_gate_detect (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .pix_in(pix_in),
        .lim_inner(lim_inner), .lim_edge(lim_edge), .var_thr(var_thr),
        .valid_out(valid_out), .pix_out(pix_out), .mask_out(mask_out), .hev_out(hev_out)
    );

    function automatic int adiff(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // behavioural decision for one line of eight taps
    function automatic void ref_line(input logic [63:0] ln, input int li, input int le,
                                     input int vt, output logic [7:0] m, output logic h);
        int px[8];
        int imax;
        int bterm;
        int act;
        for (int k = 0; k < 8; k++) px[k] = int'(ln[k*8 +: 8]);
        imax = 0;
        for (int k = 0; k < 7; k++) begin
            if (k != 3 && adiff(px[k], px[k+1]) > imax) imax = adiff(px[k], px[k+1]);
        end
        bterm = 2 * adiff(px[3], px[4]);
        if (bterm > 255) bterm = 255;
        bterm = bterm + adiff(px[2], px[5]) / 2;
        if (bterm > 255) bterm = 255;
        m = (imax <= li && bterm <= le) ? 8'hFF : 8'h00;
        act = adiff(px[2], px[3]);
        if (adiff(px[4], px[5]) > act) act = adiff(px[4], px[5]);
        h = (act > vt);
    endfunction

    function automatic logic [63:0] mk(input int p3, input int p2, input int p1, input int p0,
                                       input int q0, input int q1, input int q2, input int q3);
        return {8'(q3), 8'(q2), 8'(q1), 8'(q0), 8'(p0), 8'(p1), 8'(p2), 8'(p3)};
    endfunction

    function automatic logic [63:0] rnd_line();
        int base;
        int v;
        logic [63:0] r;
        base = int'($urandom_range(0, 255));
        for (int k = 0; k < 8; k++) begin
            v = base + int'($urandom_range(0, 40)) - 20;
            if (v < 0) v = 0;
            if (v > 255) v = 255;
            r[k*8 +: 8] = 8'(v);
        end
        return r;
    endfunction

    task automatic check(input string what, input logic [LANES*LW-1:0] act,
                         input logic [LANES*LW-1:0] expv);
        checks++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
        end
    endtask

    // one clock: reference updates at the edge, outputs compared mid-cycle
    task automatic step();
        logic [7:0] m;
        logic h;
        @(posedge clk);
        if (!rst_n) begin
            exp_vld = 1'b0; exp_pix = '0; exp_mask = '0; exp_hev = '0;
        end else begin
            exp_vld = valid_in;
            if (valid_in) begin
                exp_pix = pix_in;
                for (int n = 0; n < LANES; n++) begin
                    ref_line(pix_in[n*LW +: LW], int'(lim_inner), int'(lim_edge),
                             int'(var_thr), m, h);
                    exp_mask[n*8 +: 8] = m;
                    exp_hev[n] = h;
                end
            end
        end
        @(negedge clk);
        check("valid", LW*LANES'(valid_out), LW*LANES'(exp_vld));
        check("pix", pix_out, exp_pix);
        check("mask", (LANES*LW)'(mask_out), (LANES*LW)'(exp_mask));
        check("hev", (LANES*LW)'(hev_out), (LANES*LW)'(exp_hev));
    endtask

    task automatic drive(input logic v, input logic [LANES*LW-1:0] p,
                         input int li, input int le, input int vt);
        valid_in = v; pix_in = p;
        lim_inner = 8'(li); lim_edge = 8'(le); var_thr = 8'(vt);
        step();
    endtask

    initial begin
        // R10: outputs stay cleared while reset is held, despite live inputs
        tag = "R10";
        for (int i = 0; i < 3; i++) drive(1'b1, {$urandom, $urandom, $urandom, $urandom,
                                                 $urandom, $urandom, $urandom, $urandom}, 9, 9, 9);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, '0, 0, 0, 0);

        // R1: distinct taps per position, cross term alone decides
        tag = "R1";
        drive(1'b1, {mk(50, 50, 50, 50, 60, 60, 60, 60), mk(50, 50, 50, 50, 55, 55, 55, 55),
                     mk(10, 11, 12, 13, 14, 15, 16, 17), mk(17, 16, 15, 14, 13, 12, 11, 10)},
              1, 10, 0);

        // R2: neighbour difference at and above the inner limit, both sides
        tag = "R2";
        drive(1'b1, {mk(100, 100, 100, 100, 100, 100, 100, 111),
                     mk(100, 100, 100, 100, 100, 100, 100, 110),
                     mk(89, 100, 100, 100, 100, 100, 100, 100),
                     mk(90, 100, 100, 100, 100, 100, 100, 100)}, 10, 255, 255);

        // R3: doubled cross difference saturates; odd outer difference halves down
        tag = "R3";
        drive(1'b1, {mk(10, 10, 10, 10, 13, 13, 13, 13), mk(0, 0, 0, 0, 200, 200, 200, 200),
                     mk(10, 10, 10, 10, 13, 13, 13, 13), mk(0, 0, 0, 0, 200, 200, 200, 200)},
              255, 254, 255);
        drive(1'b1, {mk(10, 10, 10, 10, 13, 13, 13, 13), mk(0, 0, 0, 0, 200, 200, 200, 200),
                     mk(10, 10, 10, 10, 13, 13, 13, 13), mk(0, 0, 0, 0, 200, 200, 200, 200)},
              255, 255, 255);
        drive(1'b1, {mk(10, 10, 10, 10, 13, 13, 13, 13), mk(10, 10, 10, 10, 13, 13, 13, 13),
                     mk(10, 10, 10, 10, 13, 13, 13, 13), mk(10, 10, 10, 10, 13, 13, 13, 13)},
              255, 7, 255);
        drive(1'b1, {mk(10, 10, 10, 10, 13, 13, 13, 13), mk(10, 10, 10, 10, 13, 13, 13, 13),
                     mk(10, 10, 10, 10, 13, 13, 13, 13), mk(10, 10, 10, 10, 13, 13, 13, 13)},
              255, 6, 255);

        // R4: inner passes but boundary fails, and the reverse
        tag = "R4";
        drive(1'b1, {mk(0, 30, 30, 30, 30, 30, 30, 30), mk(30, 30, 30, 30, 90, 90, 90, 90),
                     mk(30, 30, 30, 30, 31, 31, 31, 31), mk(30, 30, 30, 30, 30, 30, 30, 30)},
              5, 20, 255);

        // R5: inner activity at the variance threshold and one above it
        tag = "R5";
        drive(1'b1, {mk(80, 80, 80, 80, 80, 80, 80, 80), mk(80, 80, 80, 80, 80, 86, 80, 80),
                     mk(80, 80, 86, 80, 80, 80, 80, 80), mk(80, 80, 85, 80, 80, 80, 80, 80)},
              255, 255, 5);

        // R7 R8: back-to-back accepted lines then a gap
        tag = "R7";
        for (int i = 0; i < 6; i++)
            drive(1'b1, {rnd_line(), rnd_line(), rnd_line(), rnd_line()}, 15, 40, 6);
        tag = "R8";
        drive(1'b0, {rnd_line(), rnd_line(), rnd_line(), rnd_line()}, 15, 40, 6);
        drive(1'b1, {rnd_line(), rnd_line(), rnd_line(), rnd_line()}, 12, 30, 4);

        // R9: idle cycles with wildly changing inputs must not disturb the outputs
        tag = "R9";
        for (int i = 0; i < 8; i++)
            drive(1'b0, {rnd_line(), rnd_line(), rnd_line(), rnd_line()},
                  int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                  int'($urandom_range(0, 255)));

        // R6: independent random lanes, random acceptance and thresholds
        tag = "R6";
        for (int i = 0; i < 400; i++)
            drive(1'($urandom_range(0, 3) != 0), {rnd_line(), rnd_line(), rnd_line(), rnd_line()},
                  int'($urandom_range(0, 25)), int'($urandom_range(0, 70)),
                  int'($urandom_range(0, 15)));

        // R10: reset in the middle of traffic clears everything again
        tag = "R10";
        rst_n = 1'b0;
        drive(1'b1, {rnd_line(), rnd_line(), rnd_line(), rnd_line()}, 255, 255, 0);
        rst_n = 1'b1;
        drive(1'b0, '0, 0, 0, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule